// File: doc/BRIEF.md
# Vector Logic Processor Unit

This block is the datapath of one sequencer in an associative logic processor. It holds four general vector registers of width N and reaches one row of an external associative table through a row-read port. Each instruction picks two operands from the four registers or the addressed table row. It combines them with a bitwise binary operation and passes the result through a unary operation. The final vector is written into one destination register. No arithmetic is performed on operands.

The unary stage can pack every 1 bit of its input toward the most-significant end in the same cycle ("crowding"). The lowest packed 1 then marks how many ones the vector held, which compares quality vectors without an adder at the datapath edge. A zero flag gives the OR-reduction of the result, inverted. A separate load port and a read port move vectors in and out of the register bank.

Top module: `vlp_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all four registers to zero; the registers read zero after that edge.
- R2: Binary opcode bin_op: 2'b00 passes operand A unchanged, 2'b01 is bitwise AND, 2'b10 is bitwise OR, 2'b11 is bitwise XOR of operands A and B.
- R3: Unary opcode un_op acts on the binary-stage output: 2'b00 passes it, 2'b01 inverts every bit, 2'b10 crowds the ones, and the reserved code 2'b11 behaves as pass.
- R4: Crowding yields a vector whose count of ones equals that of its input, with all ones in the most-significant positions and zeros below. An all-zero input gives all zeros and an all-ones input gives all ones.
- R5: Operand selects src_a and src_b: codes 0..3 pick registers 0..3, and codes 4..7 pick row_data. row_addr always equals row_idx, and row_data is used in the same cycle.
- R6: When valid is high, result is written into register dst at the rising edge. Other registers keep their value unless loaded, and with valid low no instruction write happens.
- R7: zero_flag is 1 exactly when every bit of result is 0.
- R8: When load_en is high, load_data is written into register load_sel at the rising edge. If an instruction writes the same register in that cycle, the instruction result wins. A load to a different register still takes effect.
- R9: rd_data shows register rd_sel combinationally, reflecting the last completed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Instruction present this cycle |
| bin_op | input | 2 | Binary opcode |
| un_op | input | 2 | Unary opcode |
| src_a | input | 3 | Operand A select |
| src_b | input | 3 | Operand B select |
| dst | input | 2 | Destination register |
| row_idx | input | RAW | Table row index of the instruction |
| row_addr | output | RAW | Row address to table memory |
| row_data | input | N | Row returned by table memory |
| load_en | input | 1 | Register load strobe |
| load_sel | input | 2 | Register to load |
| load_data | input | N | Vector to load |
| rd_sel | input | 2 | Register to read |
| rd_data | output | N | Read-out vector |
| result | output | N | Output of the unary stage |
| zero_flag | output | 1 | 1 when result is all zeros |

## Verification
Two functions can meet in one clock: an instruction writeback and a load from the register port. They may hit the same register or different ones. The bench provokes both cases with directed cycles and with random cycles where load_sel and dst are drawn from the same small range. It judges the outcome by reading every register through rd_data after the edge. A same-register clash must leave the instruction result, and a different-register pair must leave both vectors in place.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
   localparam int NREG = 4;
   localparam int RSW  = 2;
   localparam int SSW  = 3;

   typedef enum logic [1:0] {
      BIN_PASS = 2'b00,
      BIN_AND  = 2'b01,
      BIN_OR   = 2'b10,
      BIN_XOR  = 2'b11
   } bin_op_e;

   typedef enum logic [1:0] {
      UN_PASS = 2'b00,
      UN_INV  = 2'b01,
      UN_CRWD = 2'b10,
      UN_RSVD = 2'b11
   } un_op_e;
endpackage

// File: rtl/vlp_regbank.sv
module vlp_regbank
   import vlp_pkg::*;
#(
   parameter int N = 16
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wr_en,
   input  logic [RSW-1:0]           wr_sel,
   input  logic [N-1:0]             wr_data,
   input  logic                     ld_en,
   input  logic [RSW-1:0]           ld_sel,
   input  logic [N-1:0]             ld_data,
   output logic [NREG-1:0][N-1:0]   bank
);
   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)
            bank[g] <= '0;
         else if (wr_en && wr_sel == RSW'(g))
            bank[g] <= wr_data;
         else if (ld_en && ld_sel == RSW'(g))
            bank[g] <= ld_data;
      end
   end
endmodule

// File: rtl/vlp_binop.sv
module vlp_binop
   import vlp_pkg::*;
#(
   parameter int N = 16
) (
   input  logic [NREG-1:0][N-1:0] bank,
   input  logic [N-1:0]           row,
   input  logic [SSW-1:0]         sel_a,
   input  logic [SSW-1:0]         sel_b,
   input  logic [1:0]             op,
   output logic [N-1:0]           y
);
   logic [N-1:0] opa, opb;

   function automatic logic [N-1:0] pick(input logic [SSW-1:0] s,
                                         input logic [NREG-1:0][N-1:0] b,
                                         input logic [N-1:0] r);
      if (s[SSW-1]) return r;
      return b[s[RSW-1:0]];
   endfunction

   assign opa = pick(sel_a, bank, row);
   assign opb = pick(sel_b, bank, row);

   always_comb begin
      unique case (bin_op_e'(op))
         BIN_AND: y = opa & opb;
         BIN_OR:  y = opa | opb;
         BIN_XOR: y = opa ^ opb;
         default: y = opa;
      endcase
   end
endmodule

// File: rtl/vlp_crowd.sv
module vlp_crowd #(
   parameter int N = 16
) (
   input  logic [N-1:0] x,
   output logic [N-1:0] y
);
   localparam int CW = $clog2(N + 1);

   logic [CW-1:0] cnt;

   always_comb begin
      cnt = '0;
      for (int i = 0; i < N; i++)
         cnt = cnt + CW'(x[i]);
   end

   for (genvar j = 0; j < N; j++) begin : g_therm
      assign y[N-1-j] = (cnt > CW'(j));
   end
endmodule

// File: rtl/vlp_unop.sv
module vlp_unop
   import vlp_pkg::*;
#(
   parameter int N = 16,
   parameter bit HAS_CRWD = 1'b1
) (
   input  logic [N-1:0] x,
   input  logic [1:0]   op,
   output logic [N-1:0] y
);
   logic [N-1:0] packed_v;

   if (HAS_CRWD) begin : g_crwd
      vlp_crowd #(.N(N)) u_crowd (.x(x), .y(packed_v));
   end else begin : g_nocrwd
      assign packed_v = x;
   end

   always_comb begin
      unique case (un_op_e'(op))
         UN_INV:  y = ~x;
         UN_CRWD: y = packed_v;
         default: y = x;
      endcase
   end
endmodule

// File: rtl/vlp_unit.sv
module vlp_unit
   import vlp_pkg::*;
#(
   parameter int N    = 16,
   parameter int ROWS = 8,
   localparam int RAW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            valid,
   input  logic [1:0]      bin_op,
   input  logic [1:0]      un_op,
   input  logic [2:0]      src_a,
   input  logic [2:0]      src_b,
   input  logic [1:0]      dst,
   input  logic [RAW-1:0]  row_idx,
   output logic [RAW-1:0]  row_addr,
   input  logic [N-1:0]    row_data,
   input  logic            load_en,
   input  logic [1:0]      load_sel,
   input  logic [N-1:0]    load_data,
   input  logic [1:0]      rd_sel,
   output logic [N-1:0]    rd_data,
   output logic [N-1:0]    result,
   output logic            zero_flag
);
   if (N < 2) begin : g_bad_n
      $error("vlp_unit: N must be at least 2");
   end
   if (ROWS < 1) begin : g_bad_rows
      $error("vlp_unit: ROWS must be at least 1");
   end

   logic [NREG-1:0][N-1:0] reg_bank;
   logic [N-1:0]           bin_res;

   assign row_addr = row_idx;

   vlp_regbank #(.N(N)) u_bank (
      .clk(clk), .rst(rst),
      .wr_en(valid), .wr_sel(dst), .wr_data(result),
      .ld_en(load_en), .ld_sel(load_sel), .ld_data(load_data),
      .bank(reg_bank)
   );

   vlp_binop #(.N(N)) u_bin (
      .bank(reg_bank), .row(row_data),
      .sel_a(src_a), .sel_b(src_b), .op(bin_op), .y(bin_res)
   );

   vlp_unop #(.N(N), .HAS_CRWD(1'b1)) u_un (
      .x(bin_res), .op(un_op), .y(result)
   );

   assign rd_data   = reg_bank[rd_sel];
   assign zero_flag = ~|result;
endmodule

// File: rtl/vlp_unit_chk.sv
module vlp_unit_chk #(
   parameter int N = 16
) (
   input logic                clk,
   input logic                rst,
   input logic                valid,
   input logic [1:0]          un_op,
   input logic [1:0]          dst,
   input logic                load_en,
   input logic [1:0]          load_sel,
   input logic [N-1:0]        load_data,
   input logic [N-1:0]        rd_data,
   input logic [N-1:0]        result,
   input logic [N-1:0]        bin_res,
   input logic [3:0][N-1:0]   reg_bank
);
   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (reg_bank == '0));

   a_r4_crowd_count: assert property (@(posedge clk) disable iff (rst)
      (un_op == 2'b10) |-> ($countones(result) == $countones(bin_res)));

   a_r4_crowd_shape: assert property (@(posedge clk) disable iff (rst)
      (un_op == 2'b10) |-> (((~result) & ((~result) + N'(1))) == '0));

   a_r6_write_back: assert property (@(posedge clk) disable iff (rst)
      valid |=> (reg_bank[$past(dst)] == $past(result)));

   a_r8_load_lands: assert property (@(posedge clk) disable iff (rst)
      (load_en && !(valid && dst == load_sel)) |=>
         (reg_bank[$past(load_sel)] == $past(load_data)));

   a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!valid && !load_en) |=> $stable(reg_bank));
endmodule

bind vlp_unit vlp_unit_chk #(.N(N)) u_chk (
   .clk(clk), .rst(rst), .valid(valid), .un_op(un_op), .dst(dst),
   .load_en(load_en), .load_sel(load_sel), .load_data(load_data),
   .rd_data(rd_data), .result(result), .bin_res(bin_res),
   .reg_bank(reg_bank)
);

// File: tb/vlp_unit_bench.sv
`timescale 1ns/1ps
module vlp_unit_bench;
   localparam int N    = 16;
   localparam int ROWS = 8;
   localparam int RAW  = $clog2(ROWS);

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            valid = 1'b0;
   logic [1:0]      bin_op = '0, un_op = '0, dst = '0, load_sel = '0, rd_sel = '0;
   logic [2:0]      src_a = '0, src_b = '0;
   logic [RAW-1:0]  row_idx = '0, row_addr;
   logic [N-1:0]    row_data, load_data = '0, rd_data, result;
   logic            load_en = 1'b0, zero_flag;

   logic [N-1:0] table_mem [ROWS];
   logic [N-1:0] mdl [4];
   int nvec = 0, nerr = 0;
   bit done = 0;

   always #2.5 clk = ~clk;
   assign row_data = table_mem[row_addr];

   vlp_unit #(.N(N), .ROWS(ROWS)) u_vlp_unit (
      .clk(clk), .rst(rst), .valid(valid), .bin_op(bin_op), .un_op(un_op),
      .src_a(src_a), .src_b(src_b), .dst(dst), .row_idx(row_idx),
      .row_addr(row_addr), .row_data(row_data), .load_en(load_en),
      .load_sel(load_sel), .load_data(load_data), .rd_sel(rd_sel),
      .rd_data(rd_data), .result(result), .zero_flag(zero_flag)
   );

   task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
      nvec++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [N-1:0] operand(input logic [2:0] s, input logic [RAW-1:0] ri);
      if (s >= 3'd4) return table_mem[ri];
      return mdl[s[1:0]];
   endfunction

   function automatic logic [N-1:0] crowd_ref(input logic [N-1:0] x);
      logic [N-1:0] r = '0;
      int k = 0;
      for (int i = 0; i < N; i++) if (x[i]) k++;
      for (int i = 0; i < k; i++) r[N-1-i] = 1'b1;
      return r;
   endfunction

   function automatic logic [N-1:0] expect_res(input logic [1:0] bo, input logic [1:0] uo,
                                              input logic [2:0] sa, input logic [2:0] sb,
                                              input logic [RAW-1:0] ri);
      logic [N-1:0] a = operand(sa, ri), b = operand(sb, ri), t;
      case (bo)
         2'b01: t = a & b;
         2'b10: t = a | b;
         2'b11: t = a ^ b;
         default: t = a;
      endcase
      case (uo)
         2'b01: return ~t;
         2'b10: return crowd_ref(t);
         default: return t;
      endcase
   endfunction

   // One cycle: drive at negedge, check combinational outputs, let the edge commit, update model
   task automatic step(input string req, input bit v, input logic [1:0] bo, input logic [1:0] uo,
                       input logic [2:0] sa, input logic [2:0] sb, input logic [1:0] d,
                       input logic [RAW-1:0] ri, input bit le, input logic [1:0] ls,
                       input logic [N-1:0] ld);
      logic [N-1:0] e;
      @(negedge clk);
      valid = v; bin_op = bo; un_op = uo; src_a = sa; src_b = sb; dst = d;
      row_idx = ri; load_en = le; load_sel = ls; load_data = ld;
      #1;
      e = expect_res(bo, uo, sa, sb, ri);
      chk(req, result, e);
      chk("R7 zero flag", N'(zero_flag), N'(e == '0));
      chk("R5 row address", N'(row_addr), N'(ri));
      @(posedge clk);
      if (le) mdl[ls] = ld;
      if (v)  mdl[d]  = e;
   endtask

   task automatic check_regs(input string req);
      @(negedge clk);
      valid = 0; load_en = 0;
      for (int i = 0; i < 4; i++) begin
         rd_sel = 2'(i);
         #0.2;
         chk(req, rd_data, mdl[i]);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7411));
      for (int i = 0; i < ROWS; i++) table_mem[i] = N'($urandom);
      table_mem[0] = '0;
      table_mem[1] = '1;
      for (int i = 0; i < 4; i++) mdl[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 0;
      check_regs("R1 registers clear after reset");

      // R9/R8: load each register and read back
      for (int i = 0; i < 4; i++)
         step("R8 load", 0, 2'b00, 2'b00, 3'd0, 3'd0, 2'd0, '0, 1, 2'(i), N'($urandom));
      check_regs("R9 read after load");

      // R1: reset clears loaded values
      @(negedge clk); rst = 1;
      @(posedge clk); @(negedge clk); rst = 0;
      for (int i = 0; i < 4; i++) mdl[i] = '0;
      check_regs("R1 reset clears loaded registers");

      // R4 directed crowding corners
      step("R4 crowd of zero row",  1, 2'b00, 2'b10, 3'd4, 3'd0, 2'd0, 3'd0, 0, 0, '0);
      step("R4 crowd of ones row",  1, 2'b00, 2'b10, 3'd4, 3'd0, 2'd1, 3'd1, 0, 0, '0);
      step("R8 load single bit",    0, 2'b00, 2'b00, 3'd0, 3'd0, 2'd0, 3'd0, 1, 2'd2, N'(1));
      step("R4 crowd single bit",   1, 2'b00, 2'b10, 3'd2, 3'd0, 2'd3, 3'd0, 0, 0, '0);
      step("R3 reserved unary",     1, 2'b11, 2'b11, 3'd3, 3'd5, 2'd0, 3'd2, 0, 0, '0);
      step("R3 invert",             1, 2'b01, 2'b01, 3'd6, 3'd1, 2'd2, 3'd3, 0, 0, '0);
      check_regs("R6 directed writes");

      // R8 collision: same register, instruction wins
      step("R8 same-register clash", 1, 2'b10, 2'b00, 3'd4, 3'd0, 2'd1, 3'd4, 1, 2'd1, 16'hA5A5);
      check_regs("R8 instruction wins clash");
      // R8 different registers: both land
      step("R8 different-register pair", 1, 2'b11, 2'b00, 3'd4, 3'd1, 2'd0, 3'd5, 1, 2'd3, 16'h3C3C);
      check_regs("R8 both writes land");
      // R6: valid low writes nothing
      step("R6 idle cycle", 0, 2'b11, 2'b01, 3'd4, 3'd2, 2'd2, 3'd6, 0, 0, '0);
      check_regs("R6 no write when idle");

      for (int n = 0; n < 3000; n++) begin
         logic [1:0] bo = 2'($urandom), uo = 2'($urandom);
         string tag;
         tag = (uo == 2'b10) ? "R4 random crowd" :
               (uo == 2'b00) ? "R2 random binary" : "R3 random unary";
         step(tag, 1'($urandom), bo, uo, 3'($urandom), 3'($urandom), 2'($urandom),
              RAW'($urandom), ($urandom % 3) == 0, 2'($urandom), N'($urandom));
         if (n % 100 == 0) check_regs("R6 random register state");
      end
      check_regs("R9 final register state");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule